// File: doc/BRIEF.md
# Remote On/Off Fault-Latch Controller

This block sits on the secondary side of a switched-mode supply and decides whether the main output rails may run. It takes a raw, active-low on/off request and runs it through a synchronizer and a symmetric debounce filter. It then drives an active-high `rails_off` level that holds the main converter in shutdown. A debounced turn-on releases `rails_off` at once. A debounced turn-off waits a further fixed delay before it asserts `rails_off`.

An upstream qualifier watches the rails for over-voltage, under-voltage and over-current. It sends single-cycle fault pulses, and it may only report while this block holds `qual_en` high. A qualified pulse sets a fault latch. The latch forces the rails off whatever the request is doing. Only a debounced low-to-high transition of the request, or the power-on reset, clears it. Each turn-on also emits a one-cycle `blank_start` strobe, which the qualifier uses to open its start-up blanking window.

All times are counted in clock cycles. Parameters set the synchronizer depth, the debounce length and the turn-off delay.

Top module: `onoff_fault_ctl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `rails_off` is 1, `fault_held` is 0, `blank_start` is 0 and `qual_en` is 0.
- R2: The request `req_n` is active low. While it is high, `rails_off` stays 1.
- R3: A level on `req_n` must persist for DEB_CYC consecutive synchronized cycles before it is accepted. This applies to both edges, so shorter pulses leave `rails_off` unchanged.
- R4: When `req_n` falls and stays low with no fault latched, `rails_off` falls exactly SYNC_STAGES + DEB_CYC + 1 clock edges after the first edge that samples the low level.
- R5: `blank_start` is a one-cycle pulse. It is high exactly in the first cycle in which `rails_off` is 0 after each turn-on, and never at any other time.
- R6: When `req_n` returns high and stays high, `rails_off` rises exactly SYNC_STAGES + DEB_CYC + 1 + OFF_CYC edges after the first edge that samples the high level.
- R7: A `fault_pulse` sampled while `qual_en` is 1 sets `fault_held` on that edge. `rails_off` is then 1 in the same cycle, and both stay 1 while `req_n` stays low.
- R8: A `fault_pulse` sampled while `qual_en` is 0 has no effect: `fault_held` stays 0. This includes pulses while the rails are off and pulses during the turn-off delay.
- R9: Only a debounced low-to-high transition of `req_n` clears `fault_held`. A high glitch shorter than the debounce does not clear it, and a low request while it is set does not turn the rails on.
- R10: After the latch clears, a new debounced low request runs the normal turn-on sequence again, including the `blank_start` pulse.
- R11: `qual_en` is 1 exactly when the rails are on, no turn-off delay is running and `fault_held` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, synchronous, active low |
| req_n | input | 1 | Raw remote on/off request, low asks for rails on |
| fault_pulse | input | 1 | Qualified fault pulse from the rail monitor |
| rails_off | output | 1 | High holds the main rails in shutdown |
| fault_held | output | 1 | Fault latch state |
| blank_start | output | 1 | One-cycle strobe at each turn-on, starts blanking |
| qual_en | output | 1 | Allows the fault qualifier to report |

## Verification
The bench builds the block with SYNC_STAGES = 2, DEB_CYC = 8 and OFF_CYC = 3. With these values a complete debounce fits in a handful of cycles, so every transition can be exercised exhaustively: glitches just shorter than the filter, the exact turn-on and turn-off latencies, and fault pulses landing inside the turn-off delay. Because OFF_CYC is shorter than the debounce, the request cannot re-enter the on state before the delay expires. This matches the proportions of the real timing.

// File: rtl/ofl_pkg.sv
// Package: shared types for the on/off fault-latch controller.
// Assumes: nothing beyond IEEE 1800-2017.
package ofl_pkg;

    // Rail sequencing states.
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_ON   = 2'd1,
        ST_STOP = 2'd2
    } pwr_state_t;

    // Width needed to count from 0 to n-1 (at least 1 bit).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/ofl_sync.sv
// Module: ofl_sync
// Brings the asynchronous request into the clock domain through a flop chain.
// Assumes: STAGES >= 1; the chain resets to the inactive (high) request level.
module ofl_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // First stage samples the raw pin.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= din;
                end
            end else begin : g_next
                // Later stages shift the sampled level along.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/ofl_debounce.sv
// Module: ofl_debounce
// Accepts a new level only after it has differed from the accepted level for
// DEB_CYC consecutive cycles. It flags each accepted edge with a one-cycle
// strobe that appears together with the new level.
// Assumes: DEB_CYC >= 2; the accepted level resets high (rails requested off).
module ofl_debounce #(
    parameter int unsigned DEB_CYC = 38000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_stb,
    output logic fall_stb
);

    localparam int unsigned W = ofl_pkg::cnt_width(DEB_CYC);
    localparam logic [W-1:0] LAST = W'(DEB_CYC - 1);

    logic         level;
    logic [W-1:0] cnt;
    logic         differs;
    logic         accept;

    assign differs = (din != level);
    assign accept  = differs && (cnt == LAST);

    // Counts cycles of disagreement; a single agreeing cycle restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt <= '0;
        else if (!differs) cnt <= '0;
        else if (accept)   cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    // Holds the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n)      level <= 1'b1;
        else if (accept) level <= din;
    end

    // Registers the edge strobes in step with the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rise_stb <= 1'b0;
            fall_stb <= 1'b0;
        end else begin
            rise_stb <= accept &&  din;
            fall_stb <= accept && !din;
        end
    end

endmodule

// File: rtl/ofl_fault_latch.sv
// Module: ofl_fault_latch
// Sticky fault store. A qualified pulse sets it and an accepted request rise
// clears it. The clear wins when both arrive on the same edge.
// Assumes: the caller gates set_req with the qualifier enable.
module ofl_fault_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic held
);

    // Updates the latch: reset and clear dominate set.
    always_ff @(posedge clk) begin
        if (!rst_n)       held <= 1'b0;
        else if (clr_req) held <= 1'b0;
        else if (set_req) held <= 1'b1;
    end

endmodule

// File: rtl/ofl_seq.sv
// Module: ofl_seq
// Rail sequencer: turns the rails on at an accepted fall, runs the turn-off
// delay after an accepted rise and drops to off whenever the fault latch is
// set. It also makes the blanking strobe and the qualifier enable.
// Assumes: OFF_CYC >= 1; the strobes are single-cycle.
module ofl_seq
    import ofl_pkg::*;
#(
    parameter int unsigned OFF_CYC = 2300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_stb,
    input  logic fall_stb,
    input  logic fault_held,
    output logic rails_off,
    output logic blank_start,
    output logic qual_en
);

    localparam int unsigned W = cnt_width(OFF_CYC);
    localparam logic [W-1:0] LAST = W'(OFF_CYC - 1);

    pwr_state_t   state, state_nx;
    logic [W-1:0] dly_cnt;
    logic         dly_done;
    logic         turn_on;

    assign dly_done = (dly_cnt == LAST);
    assign turn_on  = (state == ST_OFF) && fall_stb && !fault_held;

    // Chooses the next sequencing state.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_OFF: begin
                if (turn_on) state_nx = ST_ON;
            end
            ST_ON: begin
                if (fault_held)    state_nx = ST_OFF;
                else if (rise_stb) state_nx = ST_STOP;
            end
            ST_STOP: begin
                if (fault_held)    state_nx = ST_OFF;
                else if (fall_stb) state_nx = ST_ON;
                else if (dly_done) state_nx = ST_OFF;
            end
            default: state_nx = ST_OFF;
        endcase
    end

    // Holds the sequencing state.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    // Counts the turn-off delay while stopping; it is zero on entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                 dly_cnt <= '0;
        else if (state != ST_STOP)  dly_cnt <= '0;
        else if (!dly_done)         dly_cnt <= dly_cnt + 1'b1;
    end

    // Marks the first powered cycle of every turn-on.
    always_ff @(posedge clk) begin
        if (!rst_n) blank_start <= 1'b0;
        else        blank_start <= turn_on;
    end

    assign rails_off = (state == ST_OFF) || fault_held;
    assign qual_en   = (state == ST_ON) && !fault_held;

endmodule

// File: rtl/onoff_fault_ctl.sv
// Module: onoff_fault_ctl (top)
// Remote on/off controller with a sticky fault latch. It chains the
// synchronizer, the debounce filter, the sequencer and the fault latch.
// Assumes: all delays are given in clock cycles; rst_n is a synchronous power-on reset.
module onoff_fault_ctl #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DEB_CYC     = 38000,
    parameter int unsigned OFF_CYC     = 2300
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_n,
    input  logic fault_pulse,
    output logic rails_off,
    output logic fault_held,
    output logic blank_start,
    output logic qual_en
);

    logic req_s;
    logic rise_stb;
    logic fall_stb;
    logic latch_set;

    ofl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (req_n),
        .dout (req_s)
    );

    ofl_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (req_s),
        .rise_stb(rise_stb),
        .fall_stb(fall_stb)
    );

    assign latch_set = fault_pulse && qual_en;

    ofl_fault_latch u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_req(latch_set),
        .clr_req(rise_stb),
        .held   (fault_held)
    );

    ofl_seq #(.OFF_CYC(OFF_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_stb   (rise_stb),
        .fall_stb   (fall_stb),
        .fault_held (fault_held),
        .rails_off  (rails_off),
        .blank_start(blank_start),
        .qual_en    (qual_en)
    );

endmodule

// File: rtl/onoff_fault_ctl_chk.sv
// Module: onoff_fault_ctl_chk
// Property checker for onoff_fault_ctl, attached by bind below.
// Assumes: rst_n is held low across the first clock edge.
module onoff_fault_ctl_chk (
    input logic clk,
    input logic rst_n,
    input logic fault_pulse,
    input logic rails_off,
    input logic fault_held,
    input logic blank_start,
    input logic qual_en,
    input logic rise_stb
);

    // R7: a held fault always keeps the rails off.
    p_fault_forces_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault_held |-> rails_off);

    // R5: the blanking strobe lasts one cycle.
    p_blank_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blank_start |=> !blank_start);

    // R5: the strobe coincides with the first powered cycle.
    p_blank_at_turn_on_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blank_start |-> (!rails_off && $past(rails_off)));

    // R8: the latch is set only by a pulse that arrived while qualified.
    p_set_needs_qual_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_held) |-> $past(fault_pulse && qual_en));

    // R9: the latch falls only after an accepted request rise.
    p_clear_on_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_held) |-> $past(rise_stb));

    // R11: the qualifier is never enabled with the rails off or latched.
    p_qual_only_on_r11: assert property (@(posedge clk) disable iff (!rst_n)
        qual_en |-> (!rails_off && !fault_held));

endmodule

bind onoff_fault_ctl onoff_fault_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_pulse(fault_pulse),
    .rails_off  (rails_off),
    .fault_held (fault_held),
    .blank_start(blank_start),
    .qual_en    (qual_en),
    .rise_stb   (rise_stb)
);

// File: tb/onoff_fault_ctl_bench.sv
module onoff_fault_ctl_bench;

    localparam int CLK_P = 10;
    localparam int SYNC  = 2;
    localparam int DEB   = 8;
    localparam int OFFD  = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_n = 1'b1;
    logic fault_pulse = 1'b0;
    logic rails_off, fault_held, blank_start, qual_en;

    int checks = 0;
    int failures = 0;
    string tag = "R1";
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    onoff_fault_ctl #(.SYNC_STAGES(SYNC), .DEB_CYC(DEB), .OFF_CYC(OFFD)) u_onoff_fault_ctl (
        .clk(clk), .rst_n(rst_n), .req_n(req_n), .fault_pulse(fault_pulse),
        .rails_off(rails_off), .fault_held(fault_held),
        .blank_start(blank_start), .qual_en(qual_en)
    );

    // Behavioural reference: queue for the sampling delay, integers for the timers.
    bit sq[$];
    bit m_acc = 1'b1;
    int m_dcnt = 0;
    bit m_rise = 1'b0, m_fall = 1'b0;
    int m_mode = 0;          // 0 off, 1 on, 2 stopping
    int m_ocnt = 0;
    bit m_latch = 1'b0;
    bit m_blank = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            sq.delete();
            for (int i = 0; i < SYNC; i++) sq.push_back(1'b1);
            m_acc = 1'b1; m_dcnt = 0; m_rise = 1'b0; m_fall = 1'b0;
            m_mode = 0; m_ocnt = 0; m_latch = 1'b0; m_blank = 1'b0;
        end else begin
            bit s_now, n_rise, n_fall, n_blank, q_old;
            s_now = sq[0];
            n_rise = 1'b0; n_fall = 1'b0; n_blank = 1'b0;
            q_old = (m_mode == 1) && !m_latch;
            if (s_now == m_acc) m_dcnt = 0;
            else if (m_dcnt == DEB - 1) begin
                m_acc = s_now; m_dcnt = 0; n_rise = s_now; n_fall = !s_now;
            end else m_dcnt++;
            if (m_mode == 0) begin
                if (m_fall && !m_latch) begin m_mode = 1; n_blank = 1'b1; end
            end else if (m_mode == 1) begin
                if (m_latch) m_mode = 0;
                else if (m_rise) begin m_mode = 2; m_ocnt = 0; end
            end else begin
                if (m_latch) m_mode = 0;
                else if (m_fall) m_mode = 1;
                else if (m_ocnt == OFFD - 1) m_mode = 0;
                else m_ocnt++;
            end
            if (m_rise) m_latch = 1'b0;
            else if (fault_pulse && q_old) m_latch = 1'b1;
            m_rise = n_rise; m_fall = n_fall; m_blank = n_blank;
            void'(sq.pop_front());
            sq.push_back(req_n);
        end
    end

    task automatic chk(input string t, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", t, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the reference, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            chk(tag, "rails_off",   rails_off,   (m_mode == 0) || m_latch);
            chk(tag, "fault_held",  fault_held,  m_latch);
            chk(tag, "blank_start", blank_start, m_blank);
            chk(tag, "qual_en",     qual_en,     (m_mode == 1) && !m_latch);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_fault;
        fault_pulse = 1'b1; cyc(1); fault_pulse = 1'b0;
    endtask

    int lat;
    int blanks;

    always @(negedge clk) if (blank_start) blanks++;

    initial begin
        blanks = 0;
        // R1: reset state
        cyc(3);
        chk("R1", "rails_off in reset", rails_off, 1'b1);
        chk("R1", "fault_held in reset", fault_held, 1'b0);
        rst_n = 1'b1;
        cyc(1);
        chk("R1", "blank_start after reset", blank_start, 1'b0);
        chk("R1", "qual_en after reset", qual_en, 1'b0);

        // R2: request high keeps rails off
        tag = "R2"; cyc(20);
        chk("R2", "rails_off with request high", rails_off, 1'b1);

        // R3: low glitch shorter than the filter
        tag = "R3"; req_n = 1'b0; cyc(DEB - 3); req_n = 1'b1; cyc(20);
        chk("R3", "rails_off after low glitch", rails_off, 1'b1);

        // R4 and R5: turn-on latency and strobe
        tag = "R4"; blanks = 0; req_n = 1'b0; lat = 0;
        while (rails_off && lat < 100) begin cyc(1); lat++; end
        checks++;
        if (lat != SYNC + DEB + 1) begin
            failures++;
            $display("FAIL R4 turn-on latency actual=%0d expected=%0d", lat, SYNC + DEB + 1);
        end
        chk("R5", "blank_start on first powered cycle", blank_start, 1'b1);
        chk("R11", "qual_en when on", qual_en, 1'b1);
        cyc(5);
        checks++;
        if (blanks != 1) begin
            failures++;
            $display("FAIL R5 strobe count actual=%0d expected=1", blanks);
        end

        // R3: high glitch while on
        tag = "R3"; req_n = 1'b1; cyc(DEB - 3); req_n = 1'b0; cyc(20);
        chk("R3", "rails_off after high glitch", rails_off, 1'b0);

        // R6 and R8: turn-off delay; fault inside it ignored
        tag = "R6"; req_n = 1'b1; lat = 0;
        while (!rails_off && lat < 100) begin
            if (lat == SYNC + DEB + 2) fault_pulse = 1'b1; else fault_pulse = 1'b0;
            cyc(1); lat++;
        end
        fault_pulse = 1'b0;
        checks++;
        if (lat != SYNC + DEB + 1 + OFFD) begin
            failures++;
            $display("FAIL R6 turn-off latency actual=%0d expected=%0d", lat, SYNC + DEB + 1 + OFFD);
        end
        chk("R8", "fault during turn-off delay", fault_held, 1'b0);

        // R8: fault while off
        tag = "R8"; cyc(5); pulse_fault(); cyc(3);
        chk("R8", "fault while off", fault_held, 1'b0);
        chk("R8", "rails stay off", rails_off, 1'b1);

        // R7: qualified fault latches and overrides the low request
        tag = "R7"; req_n = 1'b0; cyc(SYNC + DEB + 5);
        chk("R7", "rails on before fault", rails_off, 1'b0);
        fault_pulse = 1'b1; @(posedge clk); #1; fault_pulse = 1'b0;
        chk("R7", "fault_held same cycle", fault_held, 1'b1);
        chk("R7", "rails_off same cycle", rails_off, 1'b1);
        chk("R11", "qual_en dropped", qual_en, 1'b0);
        cyc(40);
        chk("R7", "latch holds with request low", fault_held, 1'b1);

        // R9: short high glitch does not clear
        tag = "R9"; req_n = 1'b1; cyc(DEB - 3); req_n = 1'b0; cyc(20);
        chk("R9", "latch after glitch", fault_held, 1'b1);
        chk("R9", "rails stay off while latched", rails_off, 1'b1);
        req_n = 1'b1; cyc(SYNC + DEB + 4);
        chk("R9", "latch cleared by accepted rise", fault_held, 1'b0);
        chk("R9", "rails off after clear", rails_off, 1'b1);

        // R10: restart after clear
        tag = "R10"; blanks = 0; req_n = 1'b0; cyc(SYNC + DEB + 6);
        chk("R10", "rails on after restart", rails_off, 1'b0);
        checks++;
        if (blanks != 1) begin
            failures++;
            $display("FAIL R10 strobe count actual=%0d expected=1", blanks);
        end
        req_n = 1'b1; cyc(SYNC + DEB + OFFD + 6);
        chk("R6", "rails off at end", rails_off, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        done = 1'b1;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule